// File: doc/BRIEF.md
# SPI configuration register slave

A small bank of 8-bit configuration registers that a host programs over a four-wire serial link in SPI mode 0. Each transaction is one 16-bit frame sent while the select line is held low. The frame starts with a read/write flag, then carries a 7-bit register address and an 8-bit data byte. A write frame stores the byte in the addressed register. A read frame returns the addressed register's byte on the serial output during the second half of the same frame.

The serial clock, select and data-in pins are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. The system clock therefore has to be several times faster than the serial clock, which may run at up to 25 MHz. All registers are visible at all times on a flat parallel bus, so the rest of the chip can use the settings directly.

The serial output has a separate enable. A pad buffer outside the block uses it to drive the pin or release it. A released pin on a pulled-up line reads as all ones.

Top module: `spi_cfg_slave`

## Requirements
- R1: A frame with exactly 16 rising serial-clock edges and a first bit of 0 writes its last 8 bits into the register at its address. Bit order is: flag first, then address bits 6 down to 0, then data bits 7 down to 0.
- R2: A frame whose first bit is 1 drives the addressed register's byte, MSB first, on `ser_dout` as bits 9 to 16 of the frame. Each output bit changes after the falling serial-clock edge that precedes the rising edge at which it is sampled.
- R3: A read frame leaves every register unchanged, whatever data bits the host sends in it.
- R4: A frame with fewer or more than 16 rising edges before select rises changes no register. The next frame is decoded afresh from its first bit.
- R5: A write to an address at or above `NUM_REGS` changes no register, and a read of such an address returns 0x00.
- R6: `ser_dout_en` is 1 while select is low and 0 while select is high, following the pin within 3 system clocks.
- R7: Reset clears every register to 0x00 and holds `ser_dout_en` at 0.
- R8: Register k appears on `cfg_regs[8k+7:8k]`.
- R9: Serial-clock and data-in activity while select is high changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host, idles low |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data to the host |
| ser_dout_en | output | 1 | Drive enable for the serial output pad |
| cfg_regs | output | NUM_REGS*8 | All register contents, register k in byte k |

## Verification
The inputs reach the decoder after two synchronizer flops, and edge detection adds one more register. A serial-output bit therefore settles about four system clocks after the falling edge that launches it. A write appears on `cfg_regs` about five clocks after select rises, and the output enable follows select within three clocks.

The bench holds each serial-clock phase for eight system clocks, so every expected value is due well inside that phase. Read bits are sampled at the end of the low phase, just before the next rising edge. Registers and the output enable are checked eight clocks after select rises, which is past every one of these latencies.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int HDR_W   = 1 + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic               rd;
        logic [DATA_W-1:0]  tx;
        logic               sdo;
        logic               clk_p;
        logic               sel_p;
    } frame_st_t;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q <= {STAGES{RST_VAL}};
        else     stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sel_n_s,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout,
    output logic              dout_en
);
    frame_st_t st_d, st_q;
    logic clk_rise, clk_fall, sel_fall, sel_rise;
    logic [FRAME_W-1:0] sh_in;

    assign clk_rise = sclk_s & ~st_q.clk_p;
    assign clk_fall = ~sclk_s & st_q.clk_p;
    assign sel_fall = ~sel_n_s & st_q.sel_p;
    assign sel_rise = sel_n_s & ~st_q.sel_p;
    assign sh_in    = {st_q.sh[FRAME_W-2:0], din_s};
    assign rd_addr  = sh_in[ADDR_W-1:0];
    assign wr_addr  = st_q.sh[FRAME_W-2:DATA_W];
    assign wr_data  = st_q.sh[DATA_W-1:0];

    always_comb begin
        st_d       = st_q;
        wr_en      = 1'b0;
        st_d.clk_p = sclk_s;
        st_d.sel_p = sel_n_s;
        if (sel_fall) begin
            st_d.cnt = '0;
            st_d.rd  = 1'b0;
            st_d.sdo = 1'b0;
        end else if (!sel_n_s) begin
            if (clk_rise) begin
                st_d.sh = sh_in;
                if (st_q.cnt != CNT_W'(CNT_MAX)) st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(HDR_W - 1)) begin
                    st_d.rd = sh_in[HDR_W-1];
                    st_d.tx = rd_data;
                end
            end
            if (clk_fall && st_q.rd && st_q.cnt >= CNT_W'(HDR_W)
                && st_q.cnt < CNT_W'(FRAME_W)) begin
                st_d.sdo = st_q.tx[DATA_W-1];
                st_d.tx  = {st_q.tx[DATA_W-2:0], 1'b0};
            end
        end else if (sel_rise) begin
            wr_en    = (st_q.cnt == CNT_W'(FRAME_W)) && !st_q.sh[FRAME_W-1];
            st_d.rd  = 1'b0;
            st_d.sdo = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.sel_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.sdo;
    assign dout_en = ~sel_n_s;

    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !(clk_fall || sel_fall || sel_rise) |=> $stable(dout)); // R2
    AST_READ_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (sel_rise && st_q.rd) |-> !wr_en); // R3
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            regs_d[k] = regs_q[k];
            if (wr_en && wr_addr == ADDR_W'(k)) regs_d[k] = wr_data;
            if (rd_addr == ADDR_W'(k)) rd_data = regs_q[k];
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rst) regs_q[k] <= '0;
            else     regs_q[k] <= regs_d[k];
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
    end

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_flat)); // R4
    AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && 32'(wr_addr) >= NUM_REGS) |=> $stable(regs_flat)); // R5
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ser_clk,
    input  logic                       ser_sel_n,
    input  logic                       ser_din,
    output logic                       ser_dout,
    output logic                       ser_dout_en,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
    logic [2:0]        pins_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    spi_cfg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst),
        .din({ser_sel_n, ser_clk, ser_din}),
        .dout(pins_s)
    );

    spi_cfg_frame u_frame (
        .clk(clk), .rst(rst),
        .sclk_s(pins_s[1]), .sel_n_s(pins_s[2]), .din_s(pins_s[0]),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(ser_dout), .dout_en(ser_dout_en)
    );

    spi_cfg_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .regs_flat(cfg_regs)
    );

    AST_EN_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(ser_sel_n) && $past(ser_sel_n, 2) && $past(ser_sel_n, 3)) |-> !ser_dout_en); // R6
    AST_EN_ON_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (!$past(ser_sel_n) && !$past(ser_sel_n, 2) && !$past(ser_sel_n, 3)) |-> ser_dout_en); // R6
endmodule

// File: tb/sim_spi_cfg_slave.sv
module sim_spi_cfg_slave;
    localparam int NR = 16;
    localparam int H  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_sel_n = 1'b1, ser_din = 1'b0;
    logic ser_dout, ser_dout_en;
    logic [NR*8-1:0] cfg_regs;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [7:0] model [NR];
    logic oe_mid;

    always #4 clk = ~clk;

    spi_cfg_slave #(.NUM_REGS(NR)) u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
        .cfg_regs(cfg_regs)
    );

    // vector: {is_read, addr, host data, expected read byte}
    localparam logic [31:0] VEC [10] = '{
        {8'h00, 8'h03, 8'hA5, 8'h00},
        {8'h00, 8'h00, 8'h3C, 8'h00},
        {8'h00, 8'h0F, 8'h81, 8'h00},
        {8'h01, 8'h03, 8'h5A, 8'hA5},
        {8'h01, 8'h00, 8'hFF, 8'h3C},
        {8'h00, 8'h14, 8'h77, 8'h00},
        {8'h01, 8'h14, 8'h00, 8'h00},
        {8'h01, 8'h0F, 8'h00, 8'h81},
        {8'h00, 8'h03, 8'h0A, 8'h00},
        {8'h01, 8'h03, 8'hC3, 8'h0A}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NR*8-1:0] model_flat();
        logic [NR*8-1:0] v;
        for (int k = 0; k < NR; k++) v[k*8 +: 8] = model[k];
        return v;
    endfunction

    task automatic xfer(input logic [31:0] bits, input int n, output logic [7:0] rx);
        rx = '0;
        @(negedge clk) ser_sel_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            ser_din = bits[n-1-i];
            repeat (H) @(negedge clk);
            if (i >= 8 && i < 16) rx = {rx[6:0], ser_dout};
            if (i == 4) oe_mid = ser_dout_en;
            ser_clk = 1'b1;
            repeat (H) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (H) @(negedge clk);
        ser_sel_n = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        for (int k = 0; k < NR; k++) model[k] = 8'h00;
        repeat (4) @(negedge clk);
        chk("R7 regs zero during reset", cfg_regs, '0);
        chk("R7 dout_en low during reset", ser_dout_en, 1'b0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            logic is_rd;
            logic [6:0] a;
            is_rd = VEC[v][24];
            a = VEC[v][22:16];
            xfer({16'h0, is_rd, a, VEC[v][15:8]}, 16, rx);
            chk("R6 dout_en high in frame", oe_mid, 1'b1);
            chk("R6 dout_en low after frame", ser_dout_en, 1'b0);
            if (is_rd) begin
                chk("R2 R5 read byte", rx, VEC[v][7:0]);
                chk("R3 read leaves regs", cfg_regs, model_flat());
            end else begin
                if (a < NR) model[a] = VEC[v][15:8];
                chk("R1 R5 R8 write result", cfg_regs, model_flat());
            end
        end

        xfer({17'h0, 1'b0, 7'h05, 8'h11} >> 1, 15, rx);
        chk("R4 short frame dropped", cfg_regs, model_flat());
        xfer({15'h0, 1'b0, 7'h05, 8'h22, 1'b1}, 17, rx);
        chk("R4 long frame dropped", cfg_regs, model_flat());

        for (int t = 0; t < 20; t++) begin
            @(negedge clk) ser_din = t[1];
            repeat (H) @(negedge clk) ser_clk = ~ser_clk;
        end
        ser_clk = 1'b0;
        repeat (H) @(negedge clk);
        chk("R9 idle clocking ignored", cfg_regs, model_flat());

        xfer({16'h0, 1'b0, 7'h05, 8'h33}, 16, rx);
        model[5] = 8'h33;
        chk("R4 recovery after aborts", cfg_regs, model_flat());
        chk("R8 reg5 byte lane", cfg_regs[5*8 +: 8], 8'h33);
        xfer({16'h0, 1'b1, 7'h05, 8'hFF}, 16, rx);
        chk("R2 read back reg5", rx, 8'h33);
        chk("R3 read data ignored", cfg_regs, model_flat());

        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 reset clears regs", cfg_regs, '0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule